// File: doc/BRIEF.md
# Low State-of-Charge Alert Logic

This block raises a low-battery interrupt for a fuel-gauge subsystem. It watches the whole-percent byte of the state-of-charge value, which arrives with an update strobe. It compares each new sample against a programmable threshold. The threshold is held as a 5-bit code that counts down from 32%. A percentage of 32 minus the code is the level to watch for.

The alert is raised only when the charge drops from at-or-above the threshold to below it between two consecutive accepted samples. Once raised, a status bit latches. An open-drain drive-enable asks the pad to pull the interrupt line low. Both stay asserted until software writes the status bit back to 0. A sleep flag from the configuration logic halts sampling, but it never disturbs a pending alert. The gauge computation and the register bus sit outside this block. They reach it only through the strobes listed below.

Top module: `soc_low_alert`

## Requirements
- R1: After synchronous reset, alert_status and alert_drive_low are 0. The threshold code is 0x1C (4%), and no previous sample is held.
- R2: The threshold in percent is 32 minus the code (code 0 = 32%, code 31 = 1%). A thr_wr write takes effect for strobes after the write edge.
- R3: An accepted update whose previous sample is at or above the threshold and whose current value is below it sets alert_status at that clock edge.
- R4: An update that rises through the threshold, stays below it, or stays at or above it never sets alert_status.
- R5: alert_status stays 1 until stat_wr with stat_wdata = 0 clears it. stat_wr with stat_wdata = 1 sets it.
- R6: When a falling crossing and a clearing write fall in the same cycle, the crossing wins and alert_status stays 1.
- R7: alert_drive_low (1 = pull the interrupt line low) always equals alert_status.
- R8: While sleep_flag is 1, update strobes are ignored: they take no sample and detect no crossing. Sleep by itself never clears or sets alert_status.
- R9: The first accepted update after reset only records a sample and never fires, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soc_value | input | 8 | State of charge, 1% per LSB |
| soc_upd | input | 1 | soc_value holds a new sample this cycle |
| thr_wr | input | 1 | Write strobe for the threshold code |
| thr_wdata | input | 5 | New threshold code (percent = 32 - code) |
| stat_wr | input | 1 | Write strobe for the alert status bit |
| stat_wdata | input | 1 | Value written to the alert status bit |
| sleep_flag | input | 1 | Gauge is asleep; strobes are ignored |
| alert_drive_low | output | 1 | Open-drain enable: 1 pulls the interrupt line low |
| alert_status | output | 1 | Latched alert bit for readback |

## Verification
Directed sequences run the charge down through the reset threshold of 4%, landing exactly on it and then one below. This separates an at-or-above/below comparison from an off-by-one variant. Rising sweeps and in-place sequences below the threshold show that only downward crossings fire. The extreme codes 0 and 31 check the inverted encoding at both ends. Coincident clear-and-crossing, the first sample after reset and strobes during sleep each isolate one priority rule. Random charge values clustered around randomly written thresholds, mixed with random status writes and sleep periods, are compared cycle by cycle with a bench model. This exposes errors in sample tracking and in write ordering.

// File: rtl/soc_alert_pkg.sv
// Shared definitions for the low state-of-charge alert logic.
// Assumes: nothing beyond standard SystemVerilog.
package soc_alert_pkg;

    // Next-state selection for the latched alert bit, in priority order.
    typedef enum logic [1:0] {
        LATCH_HOLD  = 2'd0,
        LATCH_FIRE  = 2'd1,
        LATCH_WRITE = 2'd2
    } latch_act_e;

    // Convert an inverted threshold code to a percentage (full scale minus code).
    function automatic int unsigned code_to_pct(input int unsigned code, input int unsigned code_w);
        return (32'd1 << code_w) - code;
    endfunction

endpackage

// File: rtl/alert_thresh_reg.sv
// Threshold register: holds the inverted threshold code and presents it as a percentage.
// Assumes: thr_wr is a single-cycle register write strobe; the reset code is a parameter.
module alert_thresh_reg #(
    parameter int unsigned CODE_W    = 5,
    parameter int unsigned THR_RESET = 28,
    localparam int unsigned PCT_W    = CODE_W + 1,
    localparam int unsigned FULL     = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_wr,
    input  logic [CODE_W-1:0] thr_wdata,
    output logic [PCT_W-1:0]  thr_pct
);
    logic [CODE_W-1:0] code_q;

    // Hold the programmed code; reset restores the default code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_W'(THR_RESET);
        end else if (thr_wr) begin
            code_q <= thr_wdata;
        end
    end

    // Decode: percentage equals full scale minus the stored code.
    always_comb begin
        thr_pct = PCT_W'(FULL) - {1'b0, code_q};
    end
endmodule

// File: rtl/alert_sample_track.sv
// Previous-sample tracker: remembers the last accepted charge value and whether one exists.
// Assumes: upd_live already excludes strobes that arrive while the gauge sleeps.
module alert_sample_track #(
    parameter int unsigned SOC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_live,
    input  logic [SOC_W-1:0] soc_value,
    output logic [SOC_W-1:0] prev_soc,
    output logic             prev_valid
);
    // Capture each accepted sample and mark the history as valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_soc   <= '0;
            prev_valid <= 1'b0;
        end else if (upd_live) begin
            prev_soc   <= soc_value;
            prev_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/alert_cross_detect.sv
// Falling-crossing detector: flags an accepted sample that drops below the threshold
// when the previous sample was at or above it.
// Assumes: prev_valid is 0 until a first sample has been recorded.
module alert_cross_detect #(
    parameter int unsigned SOC_W = 8,
    parameter int unsigned PCT_W = 6
) (
    input  logic             upd_live,
    input  logic             prev_valid,
    input  logic [SOC_W-1:0] prev_soc,
    input  logic [SOC_W-1:0] soc_value,
    input  logic [PCT_W-1:0] thr_pct,
    output logic             fall_hit
);
    localparam int unsigned CMP_W = (SOC_W > PCT_W) ? SOC_W : PCT_W;

    logic [CMP_W-1:0] thr_ext;
    logic [CMP_W-1:0] prev_ext;
    logic [CMP_W-1:0] cur_ext;

    // Compare at a common width: was at or above, is now below.
    always_comb begin
        thr_ext  = CMP_W'(thr_pct);
        prev_ext = CMP_W'(prev_soc);
        cur_ext  = CMP_W'(soc_value);
        fall_hit = upd_live && prev_valid && (prev_ext >= thr_ext) && (cur_ext < thr_ext);
    end
endmodule

// File: rtl/alert_latch.sv
// Alert latch: sets on a crossing and otherwise follows software writes.
// A crossing outranks a same-cycle write.
// Assumes: fall_hit is a single-cycle event; sleep has no path into this module.
module alert_latch
    import soc_alert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall_hit,
    input  logic stat_wr,
    input  logic stat_wdata,
    output logic alert_q
);
    latch_act_e act;

    // Pick the action by priority: crossing, then write, then hold.
    always_comb begin
        if (fall_hit) begin
            act = LATCH_FIRE;
        end else if (stat_wr) begin
            act = LATCH_WRITE;
        end else begin
            act = LATCH_HOLD;
        end
    end

    // Apply the selected action to the status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alert_q <= 1'b0;
        end else begin
            case (act)
                LATCH_FIRE:  alert_q <= 1'b1;
                LATCH_WRITE: alert_q <= stat_wdata;
                default:     alert_q <= alert_q;
            endcase
        end
    end
endmodule

// File: rtl/soc_low_alert.sv
// Low state-of-charge alert: latches an interrupt when the charge falls through a
// programmable threshold and drives the open-drain line until software clears it.
// Assumes: soc_value is valid whenever soc_upd is high; reset is synchronous, active low.
module soc_low_alert #(
    parameter int unsigned SOC_W     = 8,
    parameter int unsigned CODE_W    = 5,
    parameter int unsigned THR_RESET = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SOC_W-1:0]  soc_value,
    input  logic              soc_upd,
    input  logic              thr_wr,
    input  logic [CODE_W-1:0] thr_wdata,
    input  logic              stat_wr,
    input  logic              stat_wdata,
    input  logic              sleep_flag,
    output logic              alert_drive_low,
    output logic              alert_status
);
    localparam int unsigned PCT_W = CODE_W + 1;

    logic [PCT_W-1:0] thr_pct;
    logic [SOC_W-1:0] prev_soc;
    logic             prev_valid;
    logic             upd_live;
    logic             fall_hit;
    logic             alert_q;

    // Strobes are accepted only while the gauge is awake.
    always_comb begin
        upd_live = soc_upd && !sleep_flag;
    end

    alert_thresh_reg #(.CODE_W(CODE_W), .THR_RESET(THR_RESET)) u_thr (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_wdata(thr_wdata), .thr_pct(thr_pct)
    );

    alert_sample_track #(.SOC_W(SOC_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .upd_live(upd_live), .soc_value(soc_value),
        .prev_soc(prev_soc), .prev_valid(prev_valid)
    );

    alert_cross_detect #(.SOC_W(SOC_W), .PCT_W(PCT_W)) u_det (
        .upd_live(upd_live), .prev_valid(prev_valid), .prev_soc(prev_soc),
        .soc_value(soc_value), .thr_pct(thr_pct), .fall_hit(fall_hit)
    );

    alert_latch u_lat (
        .clk(clk), .rst_n(rst_n), .fall_hit(fall_hit), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .alert_q(alert_q)
    );

    // Both outputs come from the one latched bit.
    always_comb begin
        alert_status    = alert_q;
        alert_drive_low = alert_q;
    end
endmodule

// File: rtl/soc_low_alert_chk.sv
// Property checker for soc_low_alert, attached with bind below.
// Assumes: it sees the top's ports and its threshold and sample-history nets.
module soc_low_alert_chk #(
    parameter int unsigned SOC_W = 8,
    parameter int unsigned PCT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SOC_W-1:0] soc_value,
    input logic             soc_upd,
    input logic             stat_wr,
    input logic             stat_wdata,
    input logic             sleep_flag,
    input logic             alert_drive_low,
    input logic             alert_status,
    input logic [PCT_W-1:0] thr_pct,
    input logic [SOC_W-1:0] prev_soc,
    input logic             prev_valid
);
    logic fall_seen;

    // Independent view of a qualifying falling crossing.
    always_comb begin
        fall_seen = soc_upd && !sleep_flag && prev_valid &&
                    ({2'b0, prev_soc} >= (SOC_W + 2)'(thr_pct)) &&
                    ({2'b0, soc_value} < (SOC_W + 2)'(thr_pct));
    end

    // R1: reset leaves the alert clear.
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> !alert_status);

    // R3 and R6: a crossing sets the bit even with a clearing write present.
    a_r3_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fall_seen |=> alert_status);

    // R4: without a crossing or a set-write, the bit does not rise.
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_status && !fall_seen && !(stat_wr && stat_wdata)) |=> !alert_status);

    // R5: a set bit holds unless cleared by software.
    a_r5_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_status && !(stat_wr && !stat_wdata)) |=> alert_status);

    // R7: line drive tracks the status bit.
    a_r7_pin_match: assert property (@(posedge clk) disable iff (!rst_n)
        alert_drive_low == alert_status);

    // R8: with no write, sleep leaves the bit unchanged.
    a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_flag && !stat_wr) |=> $stable(alert_status));

    // R9: the first accepted sample never changes the bit.
    a_r9_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (soc_upd && !sleep_flag && !prev_valid && !stat_wr) |=> $stable(alert_status));
endmodule

bind soc_low_alert soc_low_alert_chk #(.SOC_W(SOC_W), .PCT_W(CODE_W + 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .soc_value(soc_value), .soc_upd(soc_upd),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .sleep_flag(sleep_flag),
    .alert_drive_low(alert_drive_low), .alert_status(alert_status),
    .thr_pct(thr_pct), .prev_soc(prev_soc), .prev_valid(prev_valid)
);

// File: tb/tb_soc_low_alert.sv
`timescale 1ns/1ps
// Bench for soc_low_alert: directed corners plus seeded random traffic against a model.
module tb_soc_low_alert;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] soc_value = '0;
    logic       soc_upd = 1'b0;
    logic       thr_wr = 1'b0;
    logic [4:0] thr_wdata = '0;
    logic       stat_wr = 1'b0;
    logic       stat_wdata = 1'b0;
    logic       sleep_flag = 1'b0;
    logic       alert_drive_low;
    logic       alert_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state.
    int m_code;
    int m_prev;
    bit m_valid;
    bit m_flag;

    always #2.5 clk = ~clk;

    soc_low_alert dut (
        .clk(clk), .rst_n(rst_n), .soc_value(soc_value), .soc_upd(soc_upd),
        .thr_wr(thr_wr), .thr_wdata(thr_wdata), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .sleep_flag(sleep_flag),
        .alert_drive_low(alert_drive_low), .alert_status(alert_status)
    );

    function automatic int pct_of(input int code);
        return 32 - code;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, advance the model at the edge, check at next negedge.
    task automatic step(input string req, input bit upd, input int soc,
                        input bit swr, input bit sdat,
                        input bit twr, input int tcode, input bit slp);
        bit live;
        bit hit;
        soc_value  = 8'(soc);
        soc_upd    = upd;
        stat_wr    = swr;
        stat_wdata = sdat;
        thr_wr     = twr;
        thr_wdata  = 5'(tcode);
        sleep_flag = slp;
        @(posedge clk);
        live = upd && !slp;
        hit  = live && m_valid && (m_prev >= pct_of(m_code)) && (soc < pct_of(m_code));
        if (hit)      m_flag = 1'b1;
        else if (swr) m_flag = sdat;
        if (live) begin
            m_prev  = soc;
            m_valid = 1'b1;
        end
        if (twr) m_code = tcode;
        @(negedge clk);
        soc_upd = 1'b0; stat_wr = 1'b0; thr_wr = 1'b0;
        check(req, alert_status, m_flag);
        check("R7 pin", alert_drive_low, m_flag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n   = 1'b1;
        m_code  = 28;
        m_prev  = 0;
        m_valid = 1'b0;
        m_flag  = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(posedge clk);
        do_reset();
        // R1: reset state.
        check("R1 reset status", alert_status, 1'b0);
        check("R1 reset pin", alert_drive_low, 1'b0);

        // R9: first sample of 0 is below 4% but must not fire.
        step("R9 first sample", 1, 0, 0, 0, 0, 0, 0);
        // R4: rise through threshold does not fire.
        step("R4 rise", 1, 50, 0, 0, 0, 0, 0);
        // R1/R3: reset code 4%: landing on 4 is not below.
        step("R1 default 4pct at", 1, 4, 0, 0, 0, 0, 0);
        step("R3 fall below 4pct", 1, 3, 0, 0, 0, 0, 0);
        // R5: holds through rise, clears on write 0.
        step("R5 hold on rise", 1, 60, 0, 0, 0, 0, 0);
        step("R5 clear", 0, 60, 1, 0, 0, 0, 0);
        step("R5 set by write", 0, 60, 1, 1, 0, 0, 0);
        step("R5 clear again", 0, 60, 1, 0, 0, 0, 0);
        // R2: code 0 = 32%.
        step("R2 write code 0", 0, 60, 0, 0, 1, 0, 0);
        step("R2 32pct at", 1, 32, 0, 0, 0, 0, 0);
        step("R2 32pct below", 1, 31, 0, 0, 0, 0, 0);
        step("R5 clear", 0, 31, 1, 0, 0, 0, 0);
        // R4: staying below does not fire.
        step("R4 stay below", 1, 20, 0, 0, 0, 0, 0);
        // R2: code 31 = 1%.
        step("R2 write code 31", 1, 5, 0, 0, 1, 31, 0);
        step("R2 1pct at", 1, 1, 0, 0, 0, 0, 0);
        step("R2 1pct below", 1, 0, 0, 0, 0, 0, 0);
        // R6: crossing with coincident clear stays set.
        step("R5 clear", 1, 10, 1, 0, 0, 0, 0);
        step("R6 cross beats clear", 1, 0, 1, 0, 0, 0, 0);
        step("R5 clear", 1, 10, 1, 0, 0, 0, 0);
        // R8: strobes in sleep ignored; a falling sample in sleep is not recorded either.
        step("R8 sleep fall ignored", 1, 0, 0, 0, 0, 0, 1);
        step("R8 sleep next", 1, 9, 0, 0, 0, 0, 1);
        step("R8 wake fall", 1, 0, 0, 0, 0, 0, 0);
        step("R8 sleep keeps alert", 0, 0, 0, 0, 0, 0, 1);
        step("R8 sleep keeps alert 2", 1, 80, 0, 0, 0, 0, 1);
        // R9: after a new reset, first sample still quiet.
        do_reset();
        check("R1 reset clears", alert_status, 1'b0);
        step("R9 first after reset", 1, 1, 0, 0, 0, 0, 0);

        // Random traffic around random thresholds (R3, R4, R5, R6, R8).
        for (int i = 0; i < 3000; i++) begin
            int c;
            int s;
            c = $urandom_range(0, 31);
            s = pct_of(m_code) + $urandom_range(0, 6) - 3;
            if (s < 0) s = 0;
            step("R3 random", ($urandom_range(0, 3) != 0), s,
                 ($urandom_range(0, 7) == 0), $urandom_range(0, 1),
                 ($urandom_range(0, 15) == 0), c,
                 ($urandom_range(0, 9) == 0));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule